// File: doc/BRIEF.md
# Interval Timer Channel

A single 16-bit down-counting timer channel behind a byte-wide, four-port register window. Software first writes a control byte to select the counting behaviour, then loads the 16-bit count as two byte writes to the data port, low byte first. The channel produces one output line. That line can act as an interrupt that rises at terminal count, as a periodic rate pulse, or as a single strobe that fires once per loaded count.

Software can freeze a copy of the running count with a latch command and read it back one byte at a time while the live counter keeps moving. The count can also be read live, with no latch. One byte-select flip-flop picks the low or high half for both data writes and data reads. The counter steps once per clock.

Top module: `tick_timer`

## Requirements
- R1: After reset the output is low, the counter is idle at zero, and two data-port reads return 0x00 and then 0x00.
- R2: A control byte is taken as a program word only when all of these hold: bits 7:6 are 00, bits 5:4 are 11, bit 0 is 0, and bits 3:1 are 000, 010 or 100. A byte with bits 7:6 = 00 and bits 5:4 = 00 is a latch command. Every other control byte has no effect on the output, the count or the byte select.
- R3: The data port (offset 0) takes the low byte and then the high byte. The count is used only once the high byte is written. An accepted program word or an accepted latch command returns the byte select to low.
- R4: Terminal mode (program word 0x30): after a count N is loaded, the output is low and goes high N clocks after the high-byte write. It stays high until the next accepted program word or the next high-byte write. The counter stops after it reaches zero.
- R5: Rate mode (program word 0x34): the output is low for exactly one clock, while the count equals 1, once every N clocks. The counter reloads N on its own.
- R6: In rate mode, a count written while the channel is running takes effect at the next reload. A high byte written on the same clock edge as a reload is used by that reload.
- R7: Strobe mode (program word 0x38): each low/high pair arms one countdown. That countdown pulls the output low for one clock, N clocks after the high-byte write. The output is high at all other times.
- R8: A loaded count of zero counts 65536 clocks.
- R9: A latch command freezes a copy of the count. The next two data reads return its low byte and then its high byte. A latch command given before both bytes are read is ignored.
- R10: With no latch held, data reads return the live count, low byte then high byte. A read of any offset other than 0 returns 0x00 and does not move the byte select.
- R11: Program word 0x30 stops a running channel and pulls the output low. A later load of two zero bytes starts counting again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps once per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe; the read data is valid in the same cycle |
| bus_addr | input | 2 | Port offset: 0 is data, 3 is control |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte |
| tmr_out | output | 1 | Timer output line |

## Verification
The sharpest coincidence is a rate-mode high-byte write that lands on the very clock edge where the count of 1 triggers a reload. The write path and the reload path both want to set the next count. The bench times the low byte to arrive mid-period and the high byte to arrive exactly on the reload edge. It then checks that the next low pulse comes after the new period and not the old one. A second overlap is a latch command, or a read, arriving while the counter keeps stepping. Here the snapshot values are predicted from the clock edge on which the latch command is written.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  parameter int unsigned TMR_BYTE_W = 8;
  localparam int unsigned TMR_NBYTES = 2;
  localparam int unsigned TMR_CNT_W  = TMR_NBYTES * TMR_BYTE_W;
  localparam int unsigned TMR_ADDR_W = 2;

  localparam logic [TMR_ADDR_W-1:0] PORT_DATA = 2'd0;
  localparam logic [TMR_ADDR_W-1:0] PORT_CTRL = 2'd3;

  typedef logic [TMR_BYTE_W-1:0] byte_t;
  typedef logic [TMR_CNT_W-1:0]  cnt_t;

  typedef enum logic [2:0] {
    MODE_TC     = 3'd0,
    MODE_RATE   = 3'd2,
    MODE_STROBE = 3'd4
  } tmr_mode_e;

  // control byte fields: [7:6] channel, [5:4] access, [3:1] mode, [0] bcd
  function automatic logic mode_ok(input logic [2:0] m);
    return (m == 3'd0) || (m == 3'd2) || (m == 3'd4);
  endfunction

  function automatic logic ctl_is_prog(input byte_t w);
    return (w[7:6] == 2'b00) && (w[5:4] == 2'b11) && !w[0] && mode_ok(w[3:1]);
  endfunction

  function automatic logic ctl_is_latch(input byte_t w);
    return (w[7:6] == 2'b00) && (w[5:4] == 2'b00);
  endfunction

  function automatic tmr_mode_e ctl_mode(input byte_t w);
    return tmr_mode_e'(w[3:1]);
  endfunction

  function automatic cnt_t cnt_dec(input cnt_t c);
    return c - cnt_t'(1);
  endfunction

  function automatic logic cnt_is_one(input cnt_t c);
    return c == cnt_t'(1);
  endfunction

  // rate mode: a count of one reloads, anything else steps down
  function automatic cnt_t rate_next(input cnt_t c, input cnt_t rld);
    return cnt_is_one(c) ? rld : cnt_dec(c);
  endfunction

endpackage

// File: rtl/tmr_regif.sv
`timescale 1ns/1ps
module tmr_regif
  import tmr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [TMR_ADDR_W-1:0] bus_addr,
  input  byte_t                 bus_wdata,
  input  logic                  latched_q,
  output logic                  prog_evt,
  output tmr_mode_e             prog_mode,
  output logic                  latch_evt,
  output logic                  load_evt,
  output cnt_t                  load_val,
  output logic                  data_rd_evt,
  output tmr_mode_e             mode_q,
  output logic                  byte_hi_q
);

  byte_t lo_q;
  logic  wr_ctl, wr_dat;

  assign wr_ctl      = bus_wr && (bus_addr == PORT_CTRL);
  assign wr_dat      = bus_wr && (bus_addr == PORT_DATA);
  assign data_rd_evt = bus_rd && !bus_wr && (bus_addr == PORT_DATA);

  assign prog_evt  = wr_ctl && ctl_is_prog(bus_wdata);
  assign prog_mode = ctl_mode(bus_wdata);
  assign latch_evt = wr_ctl && ctl_is_latch(bus_wdata) && !latched_q;
  assign load_evt  = wr_dat && byte_hi_q;
  assign load_val  = {bus_wdata, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_TC;
      byte_hi_q <= 1'b0;
      lo_q      <= '0;
    end else if (prog_evt) begin
      mode_q    <= prog_mode;
      byte_hi_q <= 1'b0;
    end else if (latch_evt) begin
      byte_hi_q <= 1'b0;
    end else if (wr_dat) begin
      if (!byte_hi_q) lo_q <= bus_wdata;
      byte_hi_q <= !byte_hi_q;
    end else if (data_rd_evt) begin
      byte_hi_q <= !byte_hi_q;
    end
  end

endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      prog_evt,
  input  tmr_mode_e prog_mode,
  input  logic      load_evt,
  input  cnt_t      load_val,
  input  tmr_mode_e mode_q,
  output cnt_t      count_q,
  output logic      run_q,
  output logic      tmr_out,
  output logic      reload_evt
);

  cnt_t reload_q, cnt_d, rld_d;
  logic run_d, out_d, at_one;

  assign at_one     = cnt_is_one(count_q);
  assign reload_evt = run_q && (mode_q == MODE_RATE) && at_one;

  always_comb begin
    cnt_d = count_q;
    rld_d = reload_q;
    run_d = run_q;
    out_d = tmr_out;
    if (prog_evt) begin
      run_d = 1'b0;
      out_d = (prog_mode != MODE_TC);
    end else if (load_evt) begin
      rld_d = load_val;
      run_d = 1'b1;
      case (mode_q)
        MODE_RATE: begin
          cnt_d = (!run_q || at_one) ? load_val : cnt_dec(count_q);
          out_d = !cnt_is_one(cnt_d);
        end
        MODE_STROBE: begin
          cnt_d = load_val;
          out_d = 1'b1;
        end
        default: begin
          cnt_d = load_val;
          out_d = 1'b0;
        end
      endcase
    end else if (run_q) begin
      case (mode_q)
        MODE_RATE: begin
          cnt_d = rate_next(count_q, reload_q);
          out_d = !cnt_is_one(cnt_d);
        end
        MODE_STROBE: begin
          cnt_d = cnt_dec(count_q);
          out_d = !at_one;
          if (at_one) run_d = 1'b0;
        end
        default: begin
          cnt_d = cnt_dec(count_q);
          if (at_one) begin
            run_d = 1'b0;
            out_d = 1'b1;
          end
        end
      endcase
    end else if (mode_q == MODE_STROBE) begin
      out_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      run_q    <= 1'b0;
      tmr_out  <= 1'b0;
    end else begin
      count_q  <= cnt_d;
      reload_q <= rld_d;
      run_q    <= run_d;
      tmr_out  <= out_d;
    end
  end

endmodule

// File: rtl/tmr_snap.sv
`timescale 1ns/1ps
module tmr_snap
  import tmr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prog_evt,
  input  logic                  latch_evt,
  input  logic                  data_rd_evt,
  input  logic                  byte_hi_q,
  input  logic [TMR_ADDR_W-1:0] bus_addr,
  input  cnt_t                  count_q,
  output logic                  latched_q,
  output cnt_t                  snap_q,
  output byte_t                 bus_rdata
);

  cnt_t  view;
  byte_t lanes [TMR_NBYTES];

  assign view = latched_q ? snap_q : count_q;

  for (genvar b = 0; b < TMR_NBYTES; b++) begin : g_lane
    assign lanes[b] = view[b*TMR_BYTE_W +: TMR_BYTE_W];
  end

  assign bus_rdata = (bus_addr == PORT_DATA) ? lanes[byte_hi_q] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latched_q <= 1'b0;
      snap_q    <= '0;
    end else if (prog_evt) begin
      latched_q <= 1'b0;
    end else if (latch_evt) begin
      latched_q <= 1'b1;
      snap_q    <= count_q;
    end else if (data_rd_evt && byte_hi_q) begin
      latched_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer
  import tmr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [TMR_ADDR_W-1:0] bus_addr,
  input  logic [TMR_BYTE_W-1:0] bus_wdata,
  output logic [TMR_BYTE_W-1:0] bus_rdata,
  output logic                  tmr_out
);

  logic      prog_evt, latch_evt, load_evt, data_rd_evt;
  logic      byte_hi_q, latched_q, run_q, reload_evt;
  tmr_mode_e prog_mode, mode_q;
  cnt_t      load_val, count_q, snap_q;

  tmr_regif u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .latched_q  (latched_q),
    .prog_evt   (prog_evt),
    .prog_mode  (prog_mode),
    .latch_evt  (latch_evt),
    .load_evt   (load_evt),
    .load_val   (load_val),
    .data_rd_evt(data_rd_evt),
    .mode_q     (mode_q),
    .byte_hi_q  (byte_hi_q)
  );

  tmr_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_evt  (prog_evt),
    .prog_mode (prog_mode),
    .load_evt  (load_evt),
    .load_val  (load_val),
    .mode_q    (mode_q),
    .count_q   (count_q),
    .run_q     (run_q),
    .tmr_out   (tmr_out),
    .reload_evt(reload_evt)
  );

  tmr_snap u_snap (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_evt   (prog_evt),
    .latch_evt  (latch_evt),
    .data_rd_evt(data_rd_evt),
    .byte_hi_q  (byte_hi_q),
    .bus_addr   (bus_addr),
    .count_q    (count_q),
    .latched_q  (latched_q),
    .snap_q     (snap_q),
    .bus_rdata  (bus_rdata)
  );

endmodule

// File: rtl/tick_timer_chk.sv
`timescale 1ns/1ps
module tick_timer_chk
  import tmr_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      prog_evt,
  input logic      load_evt,
  input logic      reload_evt,
  input tmr_mode_e mode_q,
  input logic      run_q,
  input cnt_t      count_q,
  input logic      tmr_out,
  input logic      latched_q,
  input cnt_t      snap_q,
  input logic      byte_hi_q
);

  p_ptr_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_evt |=> !byte_hi_q);

  p_tc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TC && tmr_out && !prog_evt && !load_evt) |=> tmr_out);

  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !prog_evt && !load_evt && !reload_evt)
      |=> count_q == cnt_t'($past(count_q) - cnt_t'(1)));

  p_rate_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RATE && run_q && !tmr_out && !prog_evt && !load_evt) |=> tmr_out);

  p_strobe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STROBE && !tmr_out && !prog_evt) |=> tmr_out);

  p_snap_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && $past(latched_q)) |-> $stable(snap_q));

endmodule

bind tick_timer tick_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prog_evt  (prog_evt),
  .load_evt  (load_evt),
  .reload_evt(reload_evt),
  .mode_q    (mode_q),
  .run_q     (run_q),
  .count_q   (count_q),
  .tmr_out   (tmr_out),
  .latched_q (latched_q),
  .snap_q    (snap_q),
  .byte_hi_q (byte_hi_q)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       tmr_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_out(tmr_out)
  );

  // {control byte, count}
  localparam logic [23:0] VEC [7] = '{
    {8'h30, 16'd20}, {8'h34, 16'd16}, {8'h38, 16'd15}, {8'h34, 16'd33},
    {8'h30, 16'd100}, {8'h38, 16'h7FFF}, {8'h34, 16'd15}
  };

  function automatic logic exp_out(input logic [7:0] c, input int n, input int k);
    case (c)
      8'h30:   return k >= n;
      8'h34:   return (k % n) != (n - 1);
      default: return k != n;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] c, input logic [15:0] n);
    wr(2'd3, c); wr(2'd0, n[7:0]); wr(2'd0, n[15:8]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 out after reset", tmr_out, 0);
    rd(2'd0, d); chk("R1 read low", d, 0);
    rd(2'd0, d); chk("R1 read high", d, 0);

    // vector table: R4 R5 R7 output patterns
    for (int i = 0; i < 7; i++) begin
      logic [7:0] c;
      int n, w, bad, bk;
      c = VEC[i][23:16]; n = int'(VEC[i][15:0]);
      w = (c == 8'h34) ? 2*n + 2 : n + 3;
      bad = 0; bk = -1;
      wr(2'd3, c); wr(2'd0, VEC[i][7:0]); wr(2'd0, VEC[i][15:8]);
      for (int k = 0; k <= w; k++) begin
        if (tmr_out !== exp_out(c, n, k)) begin
          bad++;
          if (bk < 0) bk = k;
        end
        idle(1);
      end
      chk($sformatf("R4/R5/R7 vector %0d first bad cycle", i), bk, -1);
    end

    // R11 stop a running rate channel, then restart with zero (R8)
    wr(2'd3, 8'h30);
    chk("R11 out low after stop", tmr_out, 0);
    begin
      int hi_seen = 0;
      for (int k = 0; k < 50; k++) begin
        if (tmr_out) hi_seen++;
        idle(1);
      end
      chk("R11 output quiet while stopped", hi_seen, 0);
    end
    rd(2'd0, d); rd(2'd0, d2); rd(2'd0, d2);
    chk("R11 count frozen while stopped", d2, d);
    rd(2'd0, d2);
    wr(2'd0, 8'h00); wr(2'd0, 8'h00);
    idle(65535); chk("R8 zero count still low at 65535", tmr_out, 0);
    idle(1);     chk("R8 zero count high at 65536", tmr_out, 1);

    // R2 rejected control bytes leave the running channel alone
    load(8'h30, 16'd30);
    wr(2'd3, 8'h74); wr(2'd3, 8'h35); wr(2'd3, 8'h14); wr(2'd3, 8'h3C); wr(2'd3, 8'hF4);
    chk("R2 out unchanged after bad words", tmr_out, 0);
    idle(24); chk("R2 still counting k29", tmr_out, 0);
    idle(1);  chk("R2 terminal at k30", tmr_out, 1);

    // R3 program word resets the byte select
    wr(2'd3, 8'h30); wr(2'd0, 8'hAA); idle(10);
    chk("R3 half load does not start", tmr_out, 0);
    load(8'h30, 16'd5);
    idle(4); chk("R3 low before k5", tmr_out, 0);
    idle(1); chk("R3 terminal at k5", tmr_out, 1);

    // R4 hold until a count write
    idle(20); chk("R4 held high", tmr_out, 1);
    wr(2'd0, 8'h10); chk("R4 low byte keeps output high", tmr_out, 1);
    wr(2'd0, 8'h00); chk("R4 high byte clears output", tmr_out, 0);
    idle(15); chk("R4 low at k15", tmr_out, 0);
    idle(1);  chk("R4 high at k16", tmr_out, 1);

    // R7 each pair arms one strobe
    load(8'h38, 16'd15);
    idle(15); chk("R7 strobe low at k15", tmr_out, 0);
    idle(1);  chk("R7 high after strobe", tmr_out, 1);
    begin
      int lo_seen = 0;
      for (int k = 0; k < 30; k++) begin
        if (!tmr_out) lo_seen++;
        idle(1);
      end
      chk("R7 no second strobe", lo_seen, 0);
    end
    wr(2'd0, 8'd15); wr(2'd0, 8'd0);
    idle(15); chk("R7 re-armed strobe", tmr_out, 0);
    idle(1);  chk("R7 re-armed strobe ends", tmr_out, 1);

    // R6 rewrite in rate mode, then high byte on the reload edge
    load(8'h34, 16'd20);
    idle(10); wr(2'd0, 8'd10); wr(2'd0, 8'd0);       // k12
    idle(7);  chk("R6 old period pulse k19", tmr_out, 0);
    idle(1);  chk("R6 high k20", tmr_out, 1);
    idle(8);  chk("R6 high k28", tmr_out, 1);
    idle(1);  chk("R6 new period pulse k29", tmr_out, 0);
    wr(2'd0, 8'd8);                                   // k30
    idle(8);  chk("R6 high k38", tmr_out, 1);
    idle(1);  chk("R6 pulse k39", tmr_out, 0);
    wr(2'd0, 8'd0);                                   // k40, reload edge
    idle(6);  chk("R6 high k46", tmr_out, 1);
    idle(1);  chk("R6 coincident write used at reload k47", tmr_out, 0);

    // R9 latch snapshot
    load(8'h30, 16'd1000);
    idle(10); wr(2'd3, 8'h00);                        // snap 990
    idle(5);  wr(2'd3, 8'h00);                        // ignored
    rd(2'd0, d); chk("R9 latched low", d, 8'hDE);
    wr(2'd3, 8'h00);                                  // ignored
    rd(2'd0, d); chk("R9 latched high", d, 8'h03);
    wr(2'd3, 8'h00);                                  // snap 980
    rd(2'd0, d); chk("R9 new latch low", d, 8'hD4);
    rd(2'd0, d); chk("R9 new latch high", d, 8'h03);
    rd(2'd0, d); chk("R10 live low after release", d, 8'hD1);
    rd(2'd0, d); chk("R10 live high after release", d, 8'h03);

    // R10 live reads and other offsets
    load(8'h30, 16'h1234);
    idle(3);
    rd(2'd3, d); chk("R10 control offset reads zero", d, 0);
    rd(2'd0, d); chk("R10 live low", d, 8'h30);
    rd(2'd0, d); chk("R10 live high", d, 8'h12);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule